// File: doc/BRIEF.md
# Converter Self-Calibration Sequencer

This block sits between a register interface and the core of a successive-approximation converter and drives the converter's self-calibration. Software controls it with three bits: a converter enable, a calibration-start bit and a calibration-reset bit. After the enable rises, a settling timer counts converter-clock cycles. A start request made while the timer is still counting is kept, and the calibration then begins on its own once the timer expires. The sequencer asks the core to calibrate through a level request and a one-cycle done pulse. When the done pulse arrives, it stores the 7-bit correction factor that the core returns.

The stored factor stays in place across any number of conversions. It is lost only in two cases: when the enable drops, which also aborts a calibration in progress, or when software writes the reset bit. If the reset bit is written during a calibration, the reset is held until that calibration completes, and the factor it captures is then thrown away. The start bit reads 1 from the write until the calibration finishes, and hardware clears it. While the start bit is 1, conversion requests are gated off.

Top module: `adc_cal_ctrl`

## Requirements
- R1: After synchronous reset, cal_start_o, core_cal_req_o, ready_o, factor_valid_o and factor_o all read 0.
- R2: ready_o rises after exactly STAB_CYCLES (default 14) consecutive clock edges with en_i=1. It stays high while en_i stays 1, and any edge with en_i=0 restarts the count.
- R3: A cal_start_wr_i pulse with en_i=1 makes cal_start_o read 1 after that edge. A pulse with en_i=0 is ignored, and cal_start_o stays 0.
- R4: A start request made before ready_o is 1 is held. core_cal_req_o stays 0 until ready_o is 1, and it rises on the first edge at which both cal_start_o and ready_o are 1.
- R5: core_cal_req_o stays high until the edge at which core_cal_done_i is sampled high. After that edge, core_cal_req_o and cal_start_o are both 0.
- R6: conv_go_o equals conv_req_i AND en_i AND ready_o AND NOT cal_start_o, so no conversion starts while a calibration is pending or running.
- R7: When a calibration completes, factor_o takes the value of core_factor_i that was sampled with the done pulse and factor_valid_o becomes 1. Both hold their values while conversions run.
- R8: A cal_reset_wr_i pulse while no calibration is running clears factor_o to 0 and factor_valid_o to 0 after that edge.
- R9: A cal_reset_wr_i pulse during a calibration, or in the same cycle as its done pulse, is deferred. When that calibration completes, factor_o reads 0 and factor_valid_o reads 0.
- R10: An edge with en_i=0 aborts any calibration. After it, cal_start_o, core_cal_req_o, ready_o, factor_valid_o and factor_o are all 0.
- R11: core_cal_done_i while core_cal_req_o is 0 has no effect on factor_o, factor_valid_o or cal_start_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Converter enable bit |
| cal_start_wr_i | input | 1 | One-cycle write of 1 to the calibration-start bit |
| cal_reset_wr_i | input | 1 | One-cycle write of 1 to the calibration-reset bit |
| conv_req_i | input | 1 | Conversion start request |
| conv_go_o | output | 1 | Gated conversion start to the core |
| ready_o | output | 1 | Settling time has elapsed |
| cal_start_o | output | 1 | Readback of the calibration-start bit |
| core_cal_req_o | output | 1 | Calibration request to the core (level) |
| core_cal_done_i | input | 1 | Calibration finished (one-cycle pulse from the core) |
| core_factor_i | input | FACTOR_W | Correction factor from the core, valid with the done pulse |
| factor_o | output | FACTOR_W | Stored correction factor |
| factor_valid_o | output | 1 | A factor has been captured since the last clear |

## Verification
Two events can land on the same edge: the core's done pulse and a software write of the reset bit. This also happens when a deferred reset is already pending at the moment done arrives. Directed steps drive done and the reset pulse together, and also drive a reset a few cycles into a run. In both cases factor_o and factor_valid_o must read 0, not the value the core supplied. A random phase then issues reset writes, enable drops and spurious done pulses at arbitrary points, and checks every output against a bench model on each cycle.

// File: rtl/calib_pkg.sv
package calib_pkg;

    typedef enum logic [0:0] {
        CS_IDLE = 1'b0,
        CS_RUN  = 1'b1
    } cal_state_e;

    typedef struct packed {
        logic start_pend;
        logic active;
        logic capture;
    } cal_ctl_t;

    function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] lim);
        return (v < lim) ? v + 32'd1 : v;
    endfunction

endpackage

// File: rtl/cal_stab_timer.sv
module cal_stab_timer #(
    parameter int STAB_CYCLES = 14
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    output logic stable_o
);
    import calib_pkg::*;

    localparam int CW = $clog2(STAB_CYCLES + 1);
    localparam logic [CW-1:0] LIM = CW'(STAB_CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= CW'(sat_inc(32'(cnt_q), 32'(LIM)));
        end
    end

    assign stable_o = (cnt_q == LIM);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIM);  // R2
    AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !stable_o);  // R2

endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic stable_i,
    input  logic start_wr_i,
    input  logic done_i,
    output calib_pkg::cal_ctl_t ctl_o
);
    import calib_pkg::*;

    cal_state_e state_q;
    logic       start_q;
    logic       capture;

    assign capture = (state_q == CS_RUN) && done_i;

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            state_q <= CS_IDLE;
            start_q <= 1'b0;
        end else begin
            if (capture) begin
                start_q <= 1'b0;
            end else if (start_wr_i) begin
                start_q <= 1'b1;
            end
            case (state_q)
                CS_IDLE: if (start_q && stable_i) state_q <= CS_RUN;
                CS_RUN:  if (done_i)              state_q <= CS_IDLE;
                default:                          state_q <= CS_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl_o.start_pend = start_q;
        ctl_o.active     = (state_q == CS_RUN);
        ctl_o.capture    = capture;
    end

    AST_RUN_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        (state_q == CS_RUN) |-> stable_i);  // R4
    AST_RUN_HAS_START: assert property (@(posedge clk) disable iff (rst)
        (state_q == CS_RUN) |-> start_q);  // R3
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (en_i && capture) |=> (!start_q && state_q == CS_IDLE));  // R5
    AST_OFF_NO_START: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (!start_q && state_q == CS_IDLE));  // R10

endmodule

// File: rtl/cal_factor_store.sv
module cal_factor_store #(
    parameter int FACTOR_W = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en_i,
    input  calib_pkg::cal_ctl_t ctl_i,
    input  logic                reset_wr_i,
    input  logic [FACTOR_W-1:0] factor_i,
    output logic [FACTOR_W-1:0] factor_o,
    output logic                valid_o
);
    import calib_pkg::*;

    logic [FACTOR_W-1:0] factor_q;
    logic                valid_q;
    logic                rst_pend_q;
    logic                drop_new;

    assign drop_new = rst_pend_q || reset_wr_i;

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            factor_q   <= '0;
            valid_q    <= 1'b0;
            rst_pend_q <= 1'b0;
        end else if (ctl_i.capture) begin
            rst_pend_q <= 1'b0;
            if (drop_new) begin
                factor_q <= '0;
                valid_q  <= 1'b0;
            end else begin
                factor_q <= factor_i;
                valid_q  <= 1'b1;
            end
        end else if (reset_wr_i) begin
            if (ctl_i.active) begin
                rst_pend_q <= 1'b1;
            end else begin
                factor_q <= '0;
                valid_q  <= 1'b0;
            end
        end
    end

    assign factor_o = factor_q;
    assign valid_o  = valid_q;

    AST_INVALID_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !valid_q |-> (factor_q == '0));  // R8
    AST_VALID_FROM_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_q) |-> $past(ctl_i.capture));  // R7
    AST_HOLD_NO_EVENT: assert property (@(posedge clk) disable iff (rst)
        (en_i && !ctl_i.capture && !reset_wr_i) |=> $stable(factor_q));  // R11
    AST_PEND_ONLY_RUN: assert property (@(posedge clk) disable iff (rst)
        rst_pend_q |-> ctl_i.active);  // R9

endmodule

// File: rtl/adc_cal_ctrl.sv
module adc_cal_ctrl #(
    parameter int FACTOR_W    = 7,
    parameter int STAB_CYCLES = 14
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en_i,
    input  logic                cal_start_wr_i,
    input  logic                cal_reset_wr_i,
    input  logic                conv_req_i,
    output logic                conv_go_o,
    output logic                ready_o,
    output logic                cal_start_o,
    output logic                core_cal_req_o,
    input  logic                core_cal_done_i,
    input  logic [FACTOR_W-1:0] core_factor_i,
    output logic [FACTOR_W-1:0] factor_o,
    output logic                factor_valid_o
);
    import calib_pkg::*;

    logic     stable;
    cal_ctl_t ctl;

    cal_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .en_i     (en_i),
        .stable_o (stable)
    );

    cal_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .en_i       (en_i),
        .stable_i   (stable),
        .start_wr_i (cal_start_wr_i),
        .done_i     (core_cal_done_i),
        .ctl_o      (ctl)
    );

    cal_factor_store #(.FACTOR_W(FACTOR_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .en_i       (en_i),
        .ctl_i      (ctl),
        .reset_wr_i (cal_reset_wr_i),
        .factor_i   (core_factor_i),
        .factor_o   (factor_o),
        .valid_o    (factor_valid_o)
    );

    assign ready_o        = stable;
    assign cal_start_o    = ctl.start_pend;
    assign core_cal_req_o = ctl.active;
    assign conv_go_o      = conv_req_i && en_i && stable && !ctl.start_pend;

    AST_NO_CONV_DURING_CAL: assert property (@(posedge clk) disable iff (rst)
        conv_go_o |-> (!core_cal_req_o && !cal_start_o));  // R6
    AST_REQ_WAITS_READY: assert property (@(posedge clk) disable iff (rst)
        core_cal_req_o |-> ready_o);  // R4

endmodule

// File: tb/tb_adc_cal_ctrl.sv
module tb_adc_cal_ctrl;
    localparam int FW = 7;
    localparam int S  = 14;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0, sw = 1'b0, rw = 1'b0, creq = 1'b0, done = 1'b0;
    logic [FW-1:0] cf = '0;
    logic conv_go, ready, start, req, valid;
    logic [FW-1:0] factor;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit auto_core = 0;

    int m_cnt = 0;
    bit m_start = 0, m_cal = 0, m_val = 0, m_rp = 0;
    logic [FW-1:0] m_fac = '0;

    always #10 clk = ~clk;

    adc_cal_ctrl #(.FACTOR_W(FW), .STAB_CYCLES(S)) dut (
        .clk(clk), .rst(rst), .en_i(en), .cal_start_wr_i(sw), .cal_reset_wr_i(rw),
        .conv_req_i(creq), .conv_go_o(conv_go), .ready_o(ready), .cal_start_o(start),
        .core_cal_req_o(req), .core_cal_done_i(done), .core_factor_i(cf),
        .factor_o(factor), .factor_valid_o(valid)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_go(bit r, bit e, int c, bit s);
        return r && e && (c == S) && !s;
    endfunction

    task automatic model_update();
        bit cap;
        if (!en) begin
            m_cnt = 0; m_start = 0; m_cal = 0; m_fac = '0; m_val = 0; m_rp = 0;
        end else begin
            cap = m_cal && done;
            if (cap) begin
                if (m_rp || rw) begin m_fac = '0; m_val = 0; end
                else begin m_fac = cf; m_val = 1; end
                m_rp = 0;
            end else if (rw) begin
                if (m_cal) m_rp = 1;
                else begin m_fac = '0; m_val = 0; end
            end
            if (cap) m_cal = 0;
            else if (!m_cal && m_start && (m_cnt == S)) m_cal = 1;
            if (cap) m_start = 0;
            else if (sw) m_start = 1;
            if (m_cnt < S) m_cnt++;
        end
    endtask

    task automatic cmp_all();
        check("R2 ready", int'(ready), int'(m_cnt == S));
        check("R3 start bit", int'(start), int'(m_start));
        check("R5 core request", int'(req), int'(m_cal));
        check("R6 conv gate", int'(conv_go), int'(exp_go(creq, en, m_cnt, m_start)));
        check("R7 factor", int'(factor), int'(m_fac));
        check("R7 valid", int'(valid), int'(m_val));
    endtask

    task automatic step();
        if (auto_core) begin
            done = req ? ($urandom % 4 == 0) : ($urandom % 10 == 0);
            cf = FW'($urandom);
        end
        #1 cmp_all();
        @(posedge clk);
        model_update();
        @(negedge clk);
        sw = 0; rw = 0; done = 0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int n;
        void'($urandom(32'd4711));
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1 start", int'(start), 0);
        check("R1 req", int'(req), 0);
        check("R1 ready", int'(ready), 0);
        check("R1 valid", int'(valid), 0);
        check("R1 factor", int'(factor), 0);

        // R3 start ignored while disabled
        sw = 1; step();
        check("R3 start while off", int'(start), 0);

        // R2/R4 enable, start during settling
        en = 1; sw = 1; step();
        check("R3 start set", int'(start), 1);
        n = 1;
        while (!ready && n < 40) begin
            check("R4 no req before ready", int'(req), 0);
            step(); n++;
        end
        check("R2 settle edges", n, S);
        check("R4 start still pending", int'(start), 1);
        step();
        check("R4 req after ready", int'(req), 1);
        creq = 1; step(); step();
        check("R6 conv blocked", int'(conv_go), 0);
        done = 1; cf = 7'h55; step();
        check("R5 req dropped", int'(req), 0);
        check("R5 start cleared", int'(start), 0);
        check("R7 factor captured", int'(factor), 'h55);
        check("R7 valid set", int'(valid), 1);
        repeat (5) step();
        check("R7 factor held", int'(factor), 'h55);
        #1 check("R6 conv passes", int'(conv_go), 1);

        // R11 spurious done
        done = 1; cf = 7'h11; step();
        check("R11 factor unchanged", int'(factor), 'h55);
        check("R11 start unchanged", int'(start), 0);

        // R8 idle reset
        rw = 1; step();
        check("R8 factor cleared", int'(factor), 0);
        check("R8 valid cleared", int'(valid), 0);

        // R9 reset during calibration
        sw = 1; step(); step(); step();
        rw = 1; step(); step();
        done = 1; cf = 7'h2A; step();
        check("R9 deferred factor", int'(factor), 0);
        check("R9 deferred valid", int'(valid), 0);

        // R9 reset in same cycle as done
        sw = 1; step(); step();
        done = 1; rw = 1; cf = 7'h33; step();
        check("R9 same-cycle factor", int'(factor), 0);
        check("R9 same-cycle valid", int'(valid), 0);

        // fresh capture, then R10 abort
        sw = 1; step(); step();
        done = 1; cf = 7'h7F; step();
        check("R7 max factor", int'(factor), 'h7F);
        sw = 1; step(); step();
        en = 0; step();
        check("R10 start", int'(start), 0);
        check("R10 req", int'(req), 0);
        check("R10 ready", int'(ready), 0);
        check("R10 factor", int'(factor), 0);
        check("R10 valid", int'(valid), 0);

        // random phase
        auto_core = 1;
        for (int i = 0; i < 5000; i++) begin
            en   = ($urandom % 60) != 0;
            sw   = ($urandom % 12) == 0;
            rw   = ($urandom % 25) == 0;
            creq = ($urandom % 2) == 0;
            step();
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule